// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block sends bytes on an asynchronous serial line. Each character is framed as one low start bit, eight data bits (least significant bit first) and one high stop bit. The line moves only on a one-cycle bit-rate tick supplied from outside, so the block has no rate divider of its own. The host writes a byte into a one-byte holding register. A sequencer loads that byte into a shift register and sends it. The empty flag and the single interrupt output tell the host when the holding register can take another byte.

The empty flag rises when the transmitter is first enabled. While a character is being sent, the flag does not rise when the byte moves into the shifter. It rises only on the tick that ends the first data bit of that character. The host then has about eight bit periods to write the next byte. A byte written in that window starts on the tick that ends the stop bit, so the line has no idle gap between characters.

The sequencer has four states: IDLE, START, DATA and STOP. Its transitions, each taken only on a tick while enabled, are:
- IDLE→START when the holding register is full (load).
- START→DATA after the start bit.
- DATA→DATA while data bits remain.
- DATA→STOP after the last data bit.
- STOP→START when the holding register is full (chain).
- STOP→IDLE when the holding register is empty (drain).

Dropping the enable sends any state to IDLE (abort).

Top module: `serial_tx_core`

## Requirements
- R1: While reset is asserted or `en` is low, `txd` is 1, `tx_empty` is 0 and `tx_irq` is 0.
- R2: In the clock cycle after `en` is first sampled high, `tx_empty` is 1, provided no write occurs in that cycle.
- R3: A cycle with `wr_stb` high and `en` high stores `wr_data` and makes `tx_empty` 0 in the next cycle.
- R4: A frame consists of ten bit periods, each started by one tick. The start bit is 0. Data bit k (k = 0..7) appears on the (k+2)-th tick of the frame. The stop bit, which is 1, appears on the 10th tick.
- R5: While enabled, `txd` changes only in the cycle after a cycle in which `bit_tick` is high. Between ticks it holds its value.
- R6: `tx_empty` stays 0 during the start bit and the first data bit. It becomes 1 after the 3rd tick of the frame (the tick that ends data bit 0), provided the holding register is empty.
- R7: If a byte is waiting at the tick that ends a stop bit, that same tick drives the next start bit. No idle period separates the two frames.
- R8: If no byte is waiting when the stop bit ends, `txd` stays 1 on later ticks. After a write, the next tick drives the start bit.
- R9: `tx_irq` is 1 exactly while `en` is high and `tx_empty` is 1.
- R10: Lowering `en` in the middle of a frame returns `txd` to 1 in the next cycle, lowers `tx_irq` at once, and discards both the pending byte and the byte being shifted. After `en` is raised again, the line stays idle and `tx_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Transmitter enable |
| bit_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to be sent |
| txd | output | 1 | Serial line; high when idle |
| tx_empty | output | 1 | Holding register can accept a byte |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse, and that ticks are at least one cycle apart. They also assume the host writes only while `tx_empty` is 1, so it never overwrites a byte that is still waiting. The stimulus issues every tick as a one-cycle pulse followed by idle cycles. It writes a byte only when the flag is expected to be high: before a frame, or after the tick that ends data bit 0. Enable changes are made between ticks, so the abort path is reached from a known point in a frame.

// File: rtl/stx_pkg.sv
package stx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } stx_state_e;
endpackage

// File: rtl/stx_holdreg.sv
module stx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic              first_bit,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty_flag
);
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            hold_full  <= 1'b0;
            hold_data  <= '0;
            empty_flag <= 1'b0;
        end else if (!en) begin
            en_q       <= 1'b0;
            hold_full  <= 1'b0;
            empty_flag <= 1'b0;
        end else begin
            en_q <= 1'b1;
            if (wr_stb) begin
                hold_full <= 1'b1;
                hold_data <= wr_data;
            end else if (take) begin
                hold_full <= 1'b0;
            end
            if (wr_stb)
                empty_flag <= 1'b0;
            else if (!en_q)
                empty_flag <= 1'b1;
            else if (first_bit && !hold_full)
                empty_flag <= 1'b1;
        end
    end

    // R3
    write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_stb) |=> (!empty_flag && hold_full));

    // R2
    enable_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en) && !wr_stb) |=> empty_flag);

    // R6
    first_bit_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && first_bit && !hold_full && !wr_stb) |=> empty_flag);
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
    import stx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              first_bit,
    output logic              txd
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    stx_state_e        state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              txd_q;

    assign take      = en && bit_tick && hold_full &&
                       ((state_q == ST_IDLE) || (state_q == ST_STOP));
    assign first_bit = en && bit_tick && (state_q == ST_DATA) && (cnt_q == '0);
    assign txd       = txd_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else if (bit_tick) begin
            unique case (state_q)
                ST_IDLE:  state_d = hold_full ? ST_START : ST_IDLE;
                ST_START: state_d = ST_DATA;
                ST_DATA:  state_d = (cnt_q == LAST_BIT) ? ST_STOP : ST_DATA;
                ST_STOP:  state_d = hold_full ? ST_START : ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // line and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd_q   <= 1'b1;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (!en) begin
            txd_q   <= 1'b1;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (bit_tick) begin
            unique case (state_q)
                ST_IDLE, ST_STOP: begin
                    if (hold_full) begin
                        shreg_q <= hold_data;
                        txd_q   <= 1'b0;
                    end else begin
                        txd_q   <= 1'b1;
                    end
                end
                ST_START: begin
                    txd_q   <= shreg_q[0];
                    shreg_q <= shreg_q >> 1;
                    cnt_q   <= '0;
                end
                ST_DATA: begin
                    if (cnt_q == LAST_BIT) begin
                        txd_q <= 1'b1;
                    end else begin
                        txd_q   <= shreg_q[0];
                        shreg_q <= shreg_q >> 1;
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                default: txd_q <= 1'b1;
            endcase
        end
    end

    // R4
    stop_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bit_tick && state_q == ST_DATA && cnt_q == LAST_BIT) |=> txd);

    // R7
    chain_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && take) |=> (!txd && state_q == ST_START));
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_irq
);
    logic              take;
    logic              first_bit;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;

    stx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .take       (take),
        .first_bit  (first_bit),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .empty_flag (tx_empty)
    );

    stx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bit_tick  (bit_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .first_bit (first_bit),
        .txd       (txd)
    );

    assign tx_irq = en && tx_empty;

    // R1 / R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (txd && !tx_empty));

    // R5
    line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bit_tick) |=> $stable(txd));

    // R9
    irq_low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !tx_empty) |-> !tx_irq);
endmodule

// File: tb/serial_tx_core_bench.sv
`timescale 1ns/1ps
module serial_tx_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, tx_empty, tx_irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    serial_tx_core #(.DATA_W(8)) u_serial_tx_core (
        .clk(clk), .rst_n(rst_n), .en(en), .bit_tick(bit_tick),
        .wr_stb(wr_stb), .wr_data(wr_data),
        .txd(txd), .tx_empty(tx_empty), .tx_irq(tx_irq)
    );

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
        chk(tx_empty == 1'b0, "R3 empty after write", tx_empty, 0);
    endtask

    // one tick, then two quiet cycles in which the line must hold
    task automatic tick_hold(input logic exp_line, input string req);
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
        chk(txd == exp_line, req, txd, exp_line);
        repeat (2) begin
            @(negedge clk);
            chk(txd == exp_line, "R5 line stable between ticks", txd, exp_line);
        end
    endtask

    // byte d must already be waiting; next_d is written after the empty flag rises
    task automatic run_frame(input logic [7:0] d, input bit chain, input logic [7:0] next_d);
        for (int i = 0; i < 10; i++) begin
            logic e;
            e = (i == 0) ? 1'b0 : (i <= 8) ? d[i-1] : 1'b1;
            tick_hold(e, "R4 frame bit");
            if (i < 2)
                chk(tx_empty == 1'b0, "R6 empty low early", tx_empty, 0);
            if (i == 2) begin
                chk(tx_empty == 1'b1, "R6 empty after data bit 0", tx_empty, 1);
                chk(tx_irq == 1'b1, "R9 irq follows empty", tx_irq, 1);
            end
            if (i == 3 && chain) write_byte(next_d);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 txd in reset", txd, 1);
        chk(tx_empty == 1'b0, "R1 empty in reset", tx_empty, 0);
        chk(tx_irq == 1'b0, "R1 irq in reset", tx_irq, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd == 1'b1 && tx_empty == 1'b0, "R1 disabled idle", {txd, tx_empty}, 2);
    endtask

    task automatic t_enable();
        en = 1'b1;
        @(negedge clk);
        chk(tx_empty == 1'b1, "R2 empty on enable", tx_empty, 1);
        chk(tx_irq == 1'b1, "R9 irq on enable", tx_irq, 1);
        tick_hold(1'b1, "R8 idle line with nothing written");
    endtask

    task automatic t_single();
        write_byte(8'hA5);
        chk(tx_irq == 1'b0, "R9 irq low after write", tx_irq, 0);
        run_frame(8'hA5, 1'b0, 8'h00);
        tick_hold(1'b1, "R8 idle after stop");
        tick_hold(1'b1, "R8 still idle");
        chk(tx_empty == 1'b1, "R8 empty while idle", tx_empty, 1);
    endtask

    task automatic t_chain();
        write_byte(8'h3C);
        run_frame(8'h3C, 1'b1, 8'h81);
        run_frame(8'h81, 1'b1, 8'hFF);
        run_frame(8'hFF, 1'b0, 8'h00);
        tick_hold(1'b1, "R8 idle after chain");
    endtask

    task automatic t_abort();
        write_byte(8'h00);
        tick_hold(1'b0, "R4 start bit");
        tick_hold(1'b0, "R4 data bit 0");
        tick_hold(1'b0, "R4 data bit 1");
        write_byte(8'h55);
        @(negedge clk); en = 1'b0;
        #1;
        chk(tx_irq == 1'b0, "R10 irq drops at once", tx_irq, 0);
        @(negedge clk);
        chk(txd == 1'b1, "R10 line idle after disable", txd, 1);
        chk(tx_empty == 1'b0, "R1 empty low while disabled", tx_empty, 0);
        tick_hold(1'b1, "R1 line idle while disabled");
        en = 1'b1;
        @(negedge clk);
        chk(tx_empty == 1'b1, "R10 empty after re-enable", tx_empty, 1);
        tick_hold(1'b1, "R10 pending byte discarded");
        tick_hold(1'b1, "R10 line stays idle");
    endtask

    initial begin
        t_reset();
        t_enable();
        t_single();
        t_chain();
        t_abort();
        report();
    end
endmodule